// File: doc/BRIEF.md
# Interrupt Request Latch Controller

This block collects interrupt requests from a handful of sources, raises one pending line towards a processor, and returns a vector code during the processor's acknowledge and vector-read handshake. There are three kinds of source, each with its own clearing rules. The first is one external pin that can be set to edge or level detection. The second is a group of internal peripheral sources, each set by a single-cycle pulse. The third is one serial-receive source.

Software controls the block through a small write port with two registers. A mode register chooses how the pin is detected. A clear register takes a source's vector code and drops that source's flag. The processor first strobes `ack_i`, which records the highest-priority source that is requesting at that moment. It then strobes `vec_rd_i` to read the vector. If the recorded request has gone away in between, the vector read returns a default code.

Top module: `irq_latch_ctrl`

## Requirements
- R1: In level mode (mode register bit 0 = 1), the pin request is the synchronized pin input. There is no memory, so the pin's contribution to `pending_o` disappears two clock edges after the pin goes low.
- R2: In edge mode (mode register bit 0 = 0, the value after reset), a rising edge on the synchronized pin sets a pin flag. The flag stays set after the pin returns low.
- R3: A mode-register write that moves the pin from edge mode to level mode clears the pin flag. This clear wins over a simultaneous edge set.
- R4: A mode-register write that moves the pin from level mode to edge mode keeps a flag that was set while the pin was high in level mode.
- R5: A clear-register write (`wr_addr_i` = 1) whose data equals a source's low code byte clears that flag. Pin code = 0x0A; peripheral i code = 0x10+i.
- R6: The serial-receive flag is set by `rx_full_i`. It is cleared only by reset or by `rxbuf_rd_i`. A clear-register write of its code 0x20 leaves it set.
- R7: If no source is recorded at acknowledge time, or the recorded request is gone when the vector is read, `vec_o` reads 0x0008 during `vec_rd_i`.
- R8: At acknowledge the source is chosen in a fixed order: pin, then peripherals from index 0 upward, then serial. Vector codes are pin 0x000A, peripheral i 0x0010+i, serial 0x0020. `vec_o` is 0 whenever `vec_rd_i` is low.
- R9: A vector read that returns an edge-mode pin code or a peripheral code clears that flag at the same clock edge. A vector read that returns the serial code does not clear the serial flag.
- R10: When a set (pin edge, peripheral pulse, serial set) and a clear land in the same cycle, the set wins.
- R11: `pending_o` is the OR of all current requests. After reset every flag is clear, the pin is in edge mode, and `pending_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = mode register, 1 = clear register |
| wr_data_i | input | 8 | Write data |
| pin_i | input | 1 | External pin request (asynchronous) |
| periph_set_i | input | NUM_PERIPH | Peripheral request pulses |
| rx_full_i | input | 1 | Serial-receive request pulse |
| rxbuf_rd_i | input | 1 | Receive-buffer read strobe |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| vec_rd_i | input | 1 | Vector-read strobe |
| vec_o | output | VEC_W | Vector code during vector read |
| pending_o | output | 1 | Any request active |

## Verification
The bench uses the default parameters: four peripheral sources, a two-stage pin synchronizer and 16-bit vector codes. With these values all six priority positions can be reached, the serial source sits at the lowest priority, and the synchronizer delay is short enough for a cycle-accurate bench model to track edge detection exactly. Directed sequences cover the mode-transition clears, the withdrawal-to-default case and set-versus-clear collisions. Seeded random traffic then mixes pin toggles, mode flips, clear codes and acknowledge/read pairs, and checks both outputs every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    REG_MODE  = 1'b0,
    REG_CLEAR = 1'b1
  } irq_reg_e;

  localparam logic [15:0] VEC_DEFAULT = 16'h0008;
endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // set beats a same-cycle clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/irq_pin_src.sv
module irq_pin_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic mode_we_i,
  input  logic mode_level_i,
  input  logic clr_i,
  output logic level_o,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic pin_s, prev_q;
  logic level_q, level_d;
  logic flag_q, flag_d;
  logic go_level, go_edge, set_pin;

  assign pin_s = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = pin_i;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  assign go_level = mode_we_i & mode_level_i & ~level_q;
  assign go_edge  = mode_we_i & ~mode_level_i & level_q;
  assign set_pin  = level_q ? pin_s : (pin_s & ~prev_q);
  assign level_d  = mode_we_i ? mode_level_i : level_q;

  always_comb begin
    flag_d = flag_q;
    if (go_level)     flag_d = 1'b0;
    else if (set_pin) flag_d = 1'b1;
    else if (clr_i)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      level_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= pin_s;
      level_q <= level_d;
      flag_q  <= flag_d;
    end
  end

  assign level_o = level_q;
  assign req_o   = level_q ? pin_s : flag_q;

  // entering level mode drops the latched flag
  assert_lvl_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_level |=> !flag_q);
  // leaving level mode keeps the flag
  assert_edge_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_edge && flag_q) |=> flag_q);
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb #(
  parameter int NSRC  = 6,
  parameter int VEC_W = 16,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            req_i,
  input  logic [NSRC-1:0][VEC_W-1:0] codes_i,
  input  logic [NSRC-1:0]            autoclr_en_i,
  input  logic                       ack_i,
  input  logic                       vec_rd_i,
  output logic [VEC_W-1:0]           vec_o,
  output logic [NSRC-1:0]            vclr_o,
  output logic                       pending_o
);
  import irq_pkg::*;

  logic [SRC_W-1:0] win_idx, src_q, src_d;
  logic             any_req, valid_q, valid_d, hit;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) win_idx = SRC_W'(i);
    end
  end

  assign any_req = |req_i;

  always_comb begin
    valid_d = valid_q;
    src_d   = src_q;
    if (ack_i) begin
      valid_d = any_req;
      src_d   = win_idx;
    end else if (vec_rd_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
    end else begin
      valid_q <= valid_d;
      src_q   <= src_d;
    end
  end

  assign hit = valid_q & req_i[src_q];

  always_comb begin
    vec_o = '0;
    if (vec_rd_i) vec_o = hit ? codes_i[src_q] : VEC_W'(VEC_DEFAULT);
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_vclr
      assign vclr_o[g] = vec_rd_i & hit & (src_q == SRC_W'(g)) & autoclr_en_i[g];
    end
  endgenerate

  assign pending_o = any_req;

  // an acknowledge with any request records a source
  assert_ack_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && any_req) |=> valid_q);
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int              NUM_PERIPH  = 4,
  parameter int              SYNC_STAGES = 2,
  parameter int              VEC_W       = 16,
  parameter logic [VEC_W-1:0] PIN_CODE    = 16'h000A,
  parameter logic [VEC_W-1:0] PERIPH_BASE = 16'h0010,
  parameter logic [VEC_W-1:0] SER_CODE    = 16'h0020
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic                  wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  pin_i,
  input  logic [NUM_PERIPH-1:0] periph_set_i,
  input  logic                  rx_full_i,
  input  logic                  rxbuf_rd_i,
  input  logic                  ack_i,
  input  logic                  vec_rd_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  pending_o
);
  import irq_pkg::*;

  localparam int NSRC    = NUM_PERIPH + 2;
  localparam int SER_IDX = NSRC - 1;

  logic [1:0]                 rst_sync_q;
  logic                       core_rst_n;
  logic [NSRC-1:0][VEC_W-1:0] codes;
  logic [NSRC-1:0]            req, vclr, autoclr_en;
  logic                       clr_wr, mode_we, pin_level, pin_clr, ser_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign mode_we = wr_en_i & (wr_addr_i == REG_MODE);
  assign clr_wr  = wr_en_i & (wr_addr_i == REG_CLEAR);

  assign codes[0]       = PIN_CODE;
  assign codes[SER_IDX] = SER_CODE;

  assign pin_clr = (clr_wr & (wr_data_i == PIN_CODE[7:0])) | vclr[0];

  irq_pin_src #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .pin_i       (pin_i),
    .mode_we_i   (mode_we),
    .mode_level_i(wr_data_i[0]),
    .clr_i       (pin_clr),
    .level_o     (pin_level),
    .req_o       (req[0])
  );

  generate
    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
      logic per_clr;
      assign codes[p+1] = PERIPH_BASE + VEC_W'(p);
      assign per_clr    = (clr_wr & (wr_data_i == codes[p+1][7:0])) | vclr[p+1];
      irq_flag u_flag (
        .clk  (clk),
        .rst_n(core_rst_n),
        .set_i(periph_set_i[p]),
        .clr_i(per_clr),
        .q_o  (req[p+1])
      );
    end
  endgenerate

  // the clear register has no path into the serial flag
  irq_flag u_ser (
    .clk  (clk),
    .rst_n(core_rst_n),
    .set_i(rx_full_i),
    .clr_i(rxbuf_rd_i | vclr[SER_IDX]),
    .q_o  (ser_q)
  );
  assign req[SER_IDX] = ser_q;

  assign autoclr_en = {1'b0, {NUM_PERIPH{1'b1}}, ~pin_level};

  irq_vec_arb #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .req_i       (req),
    .codes_i     (codes),
    .autoclr_en_i(autoclr_en),
    .ack_i       (ack_i),
    .vec_rd_i    (vec_rd_i),
    .vec_o       (vec_o),
    .vclr_o      (vclr),
    .pending_o   (pending_o)
  );

  // serial flag survives everything but a buffer read
  assert_ser_keep_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ser_q && !rxbuf_rd_i) |=> ser_q);
  // any active peripheral flag shows up on pending
  assert_pend_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (|req[NSRC-2:1]) |-> pending_o);
endmodule

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, pin = 1'b0, rx_set = 1'b0;
  logic rxbuf_rd = 1'b0, ack = 1'b0, vec_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] periph = 4'h0;
  logic [15:0] vec;
  logic pending;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  bit m_s1, m_s2, m_prev, m_lvl, m_pf, m_ser, m_ackv;
  bit [3:0] m_per;
  int m_src;

  always #5 clk = ~clk;

  irq_latch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pin_i(pin), .periph_set_i(periph),
    .rx_full_i(rx_set), .rxbuf_rd_i(rxbuf_rd), .ack_i(ack),
    .vec_rd_i(vec_rd), .vec_o(vec), .pending_o(pending)
  );

  function automatic bit [5:0] mreq();
    return {m_ser, m_per, (m_lvl ? m_s2 : m_pf)};
  endfunction

  function automatic int prio(bit [5:0] r);
    for (int i = 0; i < 6; i++) if (r[i]) return i;
    return 0;
  endfunction

  function automatic logic [15:0] code(int i);
    if (i == 0) return 16'h000A;
    if (i == 5) return 16'h0020;
    return 16'h0010 + 16'(i - 1);
  endfunction

  function automatic bit clrhit(logic [7:0] c);
    return wr_en && wr_addr && (wr_data == c);
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_update();
    bit [5:0] r;
    bit hit, go_lvl, setp;
    r = mreq();
    hit = m_ackv && r[m_src];
    go_lvl = wr_en && !wr_addr && wr_data[0] && !m_lvl;
    setp = m_lvl ? m_s2 : (m_s2 && !m_prev);
    if (go_lvl) m_pf = 0;
    else if (setp) m_pf = 1;
    else if (clrhit(8'h0A) || (vec_rd && hit && m_src == 0 && !m_lvl)) m_pf = 0;
    for (int i = 0; i < 4; i++) begin
      if (periph[i]) m_per[i] = 1;
      else if (clrhit(8'h10 + 8'(i)) || (vec_rd && hit && m_src == i + 1)) m_per[i] = 0;
    end
    if (rx_set) m_ser = 1;
    else if (rxbuf_rd) m_ser = 0;
    if (wr_en && !wr_addr) m_lvl = wr_data[0];
    if (ack) begin
      m_ackv = |r;
      m_src = prio(r);
    end else if (vec_rd) m_ackv = 0;
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = pin;
  endtask

  // inputs already driven at the negedge; check, clock, release pulses
  task automatic step();
    bit [5:0] r;
    logic [15:0] ev;
    #1;
    r = mreq();
    ev = 16'h0;
    if (vec_rd) ev = (m_ackv && r[m_src]) ? code(m_src) : 16'h0008;
    chk("R11 pending", {15'h0, pending}, {15'h0, |r});
    chk("R8 vector", vec, ev);
    @(posedge clk);
    model_update();
    @(negedge clk);
    wr_en = 0; periph = 0; rx_set = 0; rxbuf_rd = 0; ack = 0; vec_rd = 0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    r = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R11 reset pending", {15'h0, pending}, 16'h0);
    vec_rd = 1; #1;
    chk("R7 idle vector", vec, 16'h0008);
    step();

    pin = 1; steps(4); pin = 0; steps(3);
    chk("R2 edge latched", {15'h0, pending}, 16'h1);
    ack = 1; step();
    vec_rd = 1; #1;
    chk("R8 pin code", vec, 16'h000A);
    step(); step();
    chk("R9 autoclear pin", {15'h0, pending}, 16'h0);

    wr(1'b0, 8'h01);
    pin = 1; steps(3);
    chk("R1 level high", {15'h0, pending}, 16'h1);
    pin = 0; steps(3);
    chk("R1 level low", {15'h0, pending}, 16'h0);
    wr(1'b0, 8'h00); step();
    chk("R4 flag kept", {15'h0, pending}, 16'h1);
    wr(1'b1, 8'h0A); step();
    chk("R5 clear pin", {15'h0, pending}, 16'h0);

    pin = 1; steps(4); pin = 0; steps(3);
    wr(1'b0, 8'h01); step();
    wr(1'b0, 8'h00); step();
    chk("R3 edge to level clears", {15'h0, pending}, 16'h0);

    rx_set = 1; step();
    wr(1'b1, 8'h20); step();
    chk("R6 clear ignored", {15'h0, pending}, 16'h1);
    rxbuf_rd = 1; step();
    chk("R6 buffer read", {15'h0, pending}, 16'h0);

    periph = 4'b0100; step();
    ack = 1; step();
    wr(1'b1, 8'h12);
    vec_rd = 1; #1;
    chk("R7 withdrawn", vec, 16'h0008);
    step();

    periph = 4'b1010; rx_set = 1; step();
    ack = 1; step(); vec_rd = 1; #1;
    chk("R8 periph1 first", vec, 16'h0011);
    step();
    ack = 1; step(); vec_rd = 1; #1;
    chk("R8 periph3 next", vec, 16'h0013);
    step();
    ack = 1; step(); vec_rd = 1; #1;
    chk("R8 serial last", vec, 16'h0020);
    step(); step();
    chk("R9 serial not cleared", {15'h0, pending}, 16'h1);
    rxbuf_rd = 1; step();

    periph = 4'b0001; wr_en = 1; wr_addr = 1; wr_data = 8'h10; step();
    chk("R10 set wins", {15'h0, pending}, 16'h1);
    wr(1'b1, 8'h10);
    chk("R5 clear periph", {15'h0, pending}, 16'h0);

    for (int k = 0; k < 4000; k++) begin
      r = $urandom;
      if (r[2:0] == 0) pin = ~pin;
      if (r[7:4] == 0) begin
        wr_en = 1; wr_addr = r[8];
        if (!r[8]) wr_data = {7'h0, r[9]};
        else case (r[12:10])
          0: wr_data = 8'h0A; 1: wr_data = 8'h10; 2: wr_data = 8'h11;
          3: wr_data = 8'h12; 4: wr_data = 8'h13; 5: wr_data = 8'h20;
          default: wr_data = 8'h08;
        endcase
      end
      periph = (r[16:13] == 0) ? 4'(r[20:17]) : 4'h0;
      rx_set = (r[25:21] == 0);
      rxbuf_rd = (r[30:26] == 0);
      r = $urandom;
      ack = (r[3:0] < 2);
      vec_rd = !ack && (r[6:4] == 0);
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule